// File: doc/BRIEF.md
# Dual-Bank Video RAM Arbiter

This block lets a processor and a display fetch engine share one small video memory by taking turns according to the processor clock phase. The phase input marks each system-clock slot as either a display slot or a processor slot. In a display slot the memory is addressed from the display's 10-bit fetch address. In a processor slot it is addressed from the processor's 11-bit byte address, and the processor sees ordinary byte-wide memory that it can read and write.

The storage is two byte-wide banks of 1024 entries each. The lowest processor address bit picks the bank: even byte addresses go to one bank and odd byte addresses to the other. In wide (80-column) operation a display slot reads the same word from both banks at once and presents a 16-bit fetch: the even byte on one lane and the odd byte on the other. In narrow (40-column) operation a display slot reads a single byte and presents it on the even lane. The display lanes change only at the end of a display slot and keep their value through the processor slots that follow.

Top module: `vram_arbiter`

## Requirements
- R1: While rst_ni is low, cpu_rdata_o, vid_even_o and vid_odd_o are all 0.
- R2: In a clock cycle with phase_i = 1 (processor slot), cpu_cs_i = 1 and cpu_we_i = 1, cpu_wdata_i is stored at byte address cpu_addr_i. cpu_addr_i[0] = 0 selects the even bank and 1 selects the odd bank, and cpu_addr_i[10:1] is the word within that bank.
- R3: In a processor slot with cpu_cs_i = 1 and cpu_we_i = 0, cpu_rdata_o shows the byte stored at cpu_addr_i from the following clock edge. In every other cycle, including display slots with cpu_cs_i high, cpu_rdata_o keeps its value.
- R4: A write attempted in a display slot (phase_i = 0) changes no memory contents.
- R5: A write attempted with cpu_cs_i = 0 changes no memory contents.
- R6: In a display slot with vid_narrow_i = 0, after the clock edge vid_even_o shows the byte at byte address {vid_addr_i, 1'b0} and vid_odd_o shows the byte at {vid_addr_i, 1'b1}.
- R7: During processor slots, vid_even_o and vid_odd_o do not change.
- R8: In a display slot with vid_narrow_i = 1, after the clock edge vid_even_o shows the byte at byte address {1'b0, vid_addr_i}, and vid_odd_o keeps its value.
- R9: A processor write changes only the addressed byte. The byte in the other bank at the same word is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, one slot per cycle |
| rst_ni | input | 1 | Asynchronous active-low reset |
| phase_i | input | 1 | Slot type: 1 = processor slot, 0 = display slot |
| cpu_cs_i | input | 1 | Processor select for video RAM |
| cpu_we_i | input | 1 | Processor write enable |
| cpu_addr_i | input | 11 | Processor byte address |
| cpu_wdata_i | input | 8 | Processor write data |
| cpu_rdata_o | output | 8 | Processor read data, registered |
| vid_addr_i | input | 10 | Display fetch address |
| vid_narrow_i | input | 1 | 1 = single-byte (40-column) fetch |
| vid_even_o | output | 8 | Display lane with the even byte (the only lane used in narrow mode) |
| vid_odd_o | output | 8 | Display lane with the odd byte |

## Verification
The bench targets write attempts in display slots and with select low. A design that lets either through would show a changed byte when the location is read back. It writes one byte and reads its partner at the same word in the other bank, which catches a bank decode that is inverted or that enables both banks. It fetches at the lowest and highest display addresses, and in narrow mode at odd and even addresses, so that a swapped lane, a dropped address bit or a narrow fetch that touches the odd lane shows up. It also runs processor reads and writes between display slots, and issues a select with write disabled during a display slot, to catch display lanes that move in processor slots and read data that updates in the wrong slot.

// File: rtl/vram_pkg.sv
package vram_pkg;

  typedef enum logic {
    SLOT_VIDEO = 1'b0,
    SLOT_CPU   = 1'b1
  } slot_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/vram_bank.sv
module vram_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned AW     = 10
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // async read; the caller registers the result
  assign rdata_o = mem_q[addr_i];

endmodule

// File: rtl/vram_addr_mux.sv
module vram_addr_mux
  import vram_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter int unsigned BANK_IDX = 0
) (
  input  logic          phase_i,
  input  logic          cpu_cs_i,
  input  logic          cpu_we_i,
  input  logic [AW:0]   cpu_addr_i,
  input  logic [AW-1:0] vid_addr_i,
  input  logic          vid_narrow_i,
  output logic [AW-1:0] addr_o,
  output logic          we_o
);

  logic cpu_hit;
  logic [AW-1:0] vid_word;

  assign cpu_hit = (cpu_addr_i[0] == 1'(BANK_IDX));

  // narrow fetch: display address is a byte address into the pair
  assign vid_word = vid_narrow_i ? {1'b0, vid_addr_i[AW-1:1]} : vid_addr_i;

  always_comb begin
    addr_o = vid_word;
    we_o   = 1'b0;
    if (slot_e'(phase_i) == SLOT_CPU) begin
      addr_o = cpu_addr_i[AW:1];
      we_o   = cpu_cs_i & cpu_we_i & cpu_hit;
    end
  end

endmodule

// File: rtl/vram_vid_latch.sv
module vram_vid_latch
  import vram_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            phase_i,
  input  logic                            narrow_i,
  input  logic                            lane_sel_i,
  input  logic [NUM_BANKS-1:0][DATA_W-1:0] bank_rd_i,
  output logic [DATA_W-1:0]               even_o,
  output logic [DATA_W-1:0]               odd_o
);

  logic [DATA_W-1:0] even_q, odd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      even_q <= '0;
      odd_q  <= '0;
    end else if (slot_e'(phase_i) == SLOT_VIDEO) begin
      if (narrow_i) begin
        even_q <= bank_rd_i[lane_sel_i];
      end else begin
        even_q <= bank_rd_i[0];
        odd_q  <= bank_rd_i[1];
      end
    end
  end

  assign even_o = even_q;
  assign odd_o  = odd_q;

  p_hold_in_cpu_slot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_i |=> ($stable(even_o) && $stable(odd_o)));

  p_narrow_odd_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!phase_i && narrow_i) |=> $stable(odd_o));

endmodule

// File: rtl/vram_arbiter.sv
module vram_arbiter
  import vram_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned WORD_AW = 10
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               phase_i,
  input  logic               cpu_cs_i,
  input  logic               cpu_we_i,
  input  logic [WORD_AW:0]   cpu_addr_i,
  input  logic [DATA_W-1:0]  cpu_wdata_i,
  output logic [DATA_W-1:0]  cpu_rdata_o,
  input  logic [WORD_AW-1:0] vid_addr_i,
  input  logic               vid_narrow_i,
  output logic [DATA_W-1:0]  vid_even_o,
  output logic [DATA_W-1:0]  vid_odd_o
);

  logic [NUM_BANKS-1:0][DATA_W-1:0]  bank_rd;
  logic [NUM_BANKS-1:0][WORD_AW-1:0] bank_addr;
  logic [NUM_BANKS-1:0]              bank_we;
  logic [DATA_W-1:0]                 rdata_q;
  logic                              cpu_rd;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    vram_addr_mux #(
      .AW       (WORD_AW),
      .BANK_IDX (b)
    ) u_mux (
      .phase_i      (phase_i),
      .cpu_cs_i     (cpu_cs_i),
      .cpu_we_i     (cpu_we_i),
      .cpu_addr_i   (cpu_addr_i),
      .vid_addr_i   (vid_addr_i),
      .vid_narrow_i (vid_narrow_i),
      .addr_o       (bank_addr[b]),
      .we_o         (bank_we[b])
    );

    vram_bank #(
      .DATA_W (DATA_W),
      .AW     (WORD_AW)
    ) u_bank (
      .clk_i   (clk_i),
      .we_i    (bank_we[b]),
      .addr_i  (bank_addr[b]),
      .wdata_i (cpu_wdata_i),
      .rdata_o (bank_rd[b])
    );
  end

  vram_vid_latch #(
    .DATA_W (DATA_W)
  ) u_vid_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .phase_i    (phase_i),
    .narrow_i   (vid_narrow_i),
    .lane_sel_i (vid_addr_i[0]),
    .bank_rd_i  (bank_rd),
    .even_o     (vid_even_o),
    .odd_o      (vid_odd_o)
  );

  assign cpu_rd = (slot_e'(phase_i) == SLOT_CPU) && cpu_cs_i && !cpu_we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_q <= '0;
    else if (cpu_rd) rdata_q <= bank_rd[cpu_addr_i[0]];
  end

  assign cpu_rdata_o = rdata_q;

  p_video_slot_no_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_i |-> (bank_we == '0));

  p_single_bank_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(bank_we));

  p_deselect_no_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_cs_i |-> (bank_we == '0));

  p_rdata_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(phase_i && cpu_cs_i && !cpu_we_i) |=> $stable(cpu_rdata_o));

endmodule

// File: tb/vram_arbiter_test.sv
`timescale 1ns/1ps
module vram_arbiter_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        phase = 1'b1;
  logic        cs = 1'b0;
  logic        we = 1'b0;
  logic [10:0] caddr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [9:0]  vaddr = '0;
  logic        narrow = 1'b0;
  logic [7:0]  veven, vodd;

  always #4 clk = ~clk;

  vram_arbiter uut (
    .clk_i(clk), .rst_ni(rst_ni), .phase_i(phase), .cpu_cs_i(cs), .cpu_we_i(we),
    .cpu_addr_i(caddr), .cpu_wdata_i(wdata), .cpu_rdata_o(rdata),
    .vid_addr_i(vaddr), .vid_narrow_i(narrow), .vid_even_o(veven), .vid_odd_o(vodd)
  );

  typedef struct {
    int       due;
    int       what;
    logic [7:0] exp;
    string    tag;
  } item_t;

  item_t q[$];
  int cyc = 0;
  int n_chk = 0;
  int n_fail = 0;

  logic [7:0] ref_mem [2048];
  logic [7:0] exp_rd = 8'h00, exp_ev = 8'h00, exp_od = 8'h00;

  function automatic logic [7:0] pat(int a);
    return 8'((a * 7 + 3) ^ (a >> 3));
  endfunction

  task automatic check(input string tag, input string nm, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %02h expected %02h (cycle %0d)", tag, nm, got, exp, cyc);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    cyc++;
    while (q.size() > 0 && q[0].due <= cyc) begin
      item_t it;
      it = q.pop_front();
      case (it.what)
        0: check(it.tag, "cpu_rdata", rdata, it.exp);
        1: check(it.tag, "vid_even", veven, it.exp);
        default: check(it.tag, "vid_odd", vodd, it.exp);
      endcase
    end
  end

  // driver: one slot per call
  task automatic step(input logic ph, input logic c, input logic w, input logic [10:0] a,
                      input logic [7:0] d, input logic [9:0] va, input logic nr, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    phase = ph; cs = c; we = w; caddr = a; wdata = d; vaddr = va; narrow = nr;
    if (ph) begin
      if (c && w) ref_mem[a] = d;
      else if (c) exp_rd = ref_mem[a];
    end else if (nr) begin
      exp_ev = ref_mem[{1'b0, va}];
    end else begin
      exp_ev = ref_mem[{va, 1'b0}];
      exp_od = ref_mem[{va, 1'b1}];
    end
    it.due = cyc + 2; it.tag = tag;
    it.what = 0; it.exp = exp_rd; q.push_back(it);
    it.what = 1; it.exp = exp_ev; q.push_back(it);
    it.what = 2; it.exp = exp_od; q.push_back(it);
  endtask

  task automatic drain();
    repeat (4) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "cpu_rdata", rdata, 8'h00);
    check("R1", "vid_even", veven, 8'h00);
    check("R1", "vid_odd", vodd, 8'h00);
    @(posedge clk); #1 rst_ni = 1'b1;

    // R2: fill every byte
    for (int a = 0; a < 2048; a++) step(1, 1, 1, 11'(a), pat(a), 10'd0, 0, "R2");

    // R6: wide fetches, corners and middle
    step(0, 0, 0, 11'd0, 8'h00, 10'd0, 0, "R6");
    step(0, 0, 0, 11'd0, 8'h00, 10'd1023, 0, "R6");
    step(0, 0, 0, 11'd0, 8'h00, 10'd341, 0, "R6");

    // R7: CPU slots with traffic, lanes hold
    step(1, 1, 0, 11'd5, 8'h00, 10'd7, 0, "R7");
    step(1, 1, 1, 11'd682, 8'h3C, 10'd9, 1, "R7");
    step(1, 0, 0, 11'd0, 8'h00, 10'd2, 0, "R7");

    // R3: reads of both banks, extremes
    step(1, 1, 0, 11'd0, 8'h00, 10'd0, 0, "R3");
    step(1, 1, 0, 11'd2047, 8'h00, 10'd0, 0, "R3");
    step(1, 1, 0, 11'd682, 8'h00, 10'd0, 0, "R3");
    // R3: select with read in display slot does not update rdata
    step(0, 1, 0, 11'd100, 8'h00, 10'd50, 0, "R3");
    step(1, 0, 0, 11'd100, 8'h00, 10'd50, 0, "R3");

    // R9: write even byte, partner odd byte untouched, then reverse
    step(1, 1, 1, 11'd6, 8'hA5, 10'd0, 0, "R9");
    step(1, 1, 0, 11'd7, 8'h00, 10'd0, 0, "R9");
    step(1, 1, 0, 11'd6, 8'h00, 10'd0, 0, "R9");
    step(1, 1, 1, 11'd1021, 8'h5A, 10'd0, 0, "R9");
    step(1, 1, 0, 11'd1020, 8'h00, 10'd0, 0, "R9");
    step(1, 1, 0, 11'd1021, 8'h00, 10'd0, 0, "R9");

    // R4: writes in display slot ignored
    step(0, 1, 1, 11'd10, 8'hEE, 10'd5, 0, "R4");
    step(0, 1, 1, 11'd11, 8'hDD, 10'd5, 0, "R4");
    step(1, 1, 0, 11'd10, 8'h00, 10'd5, 0, "R4");
    step(1, 1, 0, 11'd11, 8'h00, 10'd5, 0, "R4");
    step(0, 0, 0, 11'd0, 8'h00, 10'd5, 0, "R4");

    // R5: writes with select low ignored
    step(1, 0, 1, 11'd20, 8'h77, 10'd0, 0, "R5");
    step(1, 0, 1, 11'd21, 8'h88, 10'd0, 0, "R5");
    step(1, 1, 0, 11'd20, 8'h00, 10'd0, 0, "R5");
    step(0, 0, 0, 11'd0, 8'h00, 10'd10, 0, "R5");

    // R8: narrow fetches at odd, even and top addresses
    step(0, 0, 0, 11'd0, 8'h00, 10'd7, 1, "R8");
    step(0, 0, 0, 11'd0, 8'h00, 10'd6, 1, "R8");
    step(0, 0, 0, 11'd0, 8'h00, 10'd1023, 1, "R8");
    step(1, 0, 0, 11'd0, 8'h00, 10'd0, 1, "R8");
    step(0, 0, 0, 11'd0, 8'h00, 10'd1020, 1, "R8");

    // R6: interleaved slots, fresh data seen by display
    for (int k = 0; k < 16; k++) begin
      step(1, 1, 1, 11'(k * 130 + 1), 8'(k * 17 + 9), 10'd0, 0, "R6");
      step(0, 0, 0, 11'd0, 8'h00, 10'(k * 65), 0, "R6");
      step(1, 1, 1, 11'(k * 65 * 2), 8'(k * 29 + 1), 10'(k * 65), 0, "R6");
      step(0, 0, 0, 11'd0, 8'h00, 10'(k * 65), 0, "R6");
    end

    drain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule